// File: doc/BRIEF.md
# Receive FIFO Transfer Request Generator

This block drives the request line that tells an external DMA engine or host that data from the receive FIFO is ready to read. It watches the FIFO occupancy of the frame being received, together with pulses marking where a frame starts and ends and whether an address match was seen. From these it decides when the reader should be called in. A frame does not raise the request until a fixed first gate of bytes has built up. After that first burst has been read out, the request follows a programmable watermark. At the end of the frame the request stays up until every remaining byte has been taken.

Two options change the first gate. In runt-accept mode, a frame that ends before the gate may still be handed over, but only if an address match was flagged. In low-latency mode, the first gate drops to a small level, followed by a short settling delay. A receive-enable bit masks the request entirely while the frame tracking carries on. The request is registered, so it reflects the inputs sampled at the previous clock edge.

Top module: `rx_req_gen`

## Requirements
- R1: After reset the request is low, and it stays low until a frame start pulse has been seen.
- R2: Without low-latency mode, the first request of a frame rises only once occupancy reaches 64 bytes. Once raised, it holds while occupancy is non-zero. When occupancy first returns to zero, the watermark phase begins.
- R3: In the watermark phase the request is high exactly while occupancy is at or above the level chosen by `wm_sel`: 2'b00 selects 16, 2'b01 selects 32 and 2'b10 selects 64.
- R4: The unused code 2'b11 of `wm_sel` selects 64 bytes.
- R5: While `rx_enable` is low, the request is low on the following cycle. Frame tracking continues regardless.
- R6: After `frame_end` the request is high while occupancy is non-zero. The frame is closed on the first cycle occupancy is zero, and the request is then low.
- R7: In runt-accept mode, a frame ending before its first gate raises the request at its end if `addr_match` was pulsed since `frame_start` or pulses in the same cycle as `frame_end`.
- R8: In runt-accept mode, a frame that ends before its first gate with no address match is dropped without a request. This does not apply if the gate passes in that same cycle.
- R9: Without runt-accept mode, a frame ending before its first gate (for example a padded frame whose pad was stripped) raises the request at its end.
- R10: In low-latency mode, the first gate passes at the third consecutive sampled cycle in which occupancy is at least 12. The request rises on that edge.
- R11: The request is registered. Its value in a cycle reflects state and inputs sampled at the preceding clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_enable | input | 1 | Receive enable; masks the request when low |
| wm_sel | input | 2 | Watermark code: 00=16, 01=32, 10=64, 11=64 bytes |
| runt_accept | input | 1 | Hand over short frames that have an address match |
| low_latency | input | 1 | Lower the first gate to 12 bytes plus a settling delay |
| frame_start | input | 1 | One-cycle pulse: a new frame begins |
| frame_end | input | 1 | One-cycle pulse: last byte of the frame written |
| addr_match | input | 1 | Pulse: internal or external address match for this frame |
| fifo_count | input | CNT_W | Bytes of the current frame held in the receive FIFO |
| rx_req | output | 1 | Receive data transfer request |

## Verification
The bench builds the block with its default parameters: an 8-bit occupancy, a 64-byte first gate, a 12-byte low-latency level with a 2-cycle delay, and watermarks of 16, 32 and 64. These values bring every watermark code, both gate paths and the boundary at occupancy 63 versus 64 within reach of frames of a few dozen cycles. Occupancy ramps past each threshold by one byte per cycle, so the exact rising cycle is visible. Short frames are ended below the gate with and without a match, in both runt modes.

// File: rtl/rxreq_pkg.sv
package rxreq_pkg;

    // Frame tracking phase
    typedef enum logic [2:0] {
        PH_IDLE   = 3'd0,  // no frame in progress
        PH_FIRST  = 3'd1,  // waiting for the first gate
        PH_BURST  = 3'd2,  // first request raised, held until empty
        PH_STREAM = 3'd3,  // watermark governs
        PH_DRAIN  = 3'd4   // end seen, flush remaining bytes
    } phase_e;

    typedef struct packed {
        phase_e phase;
        logic   matched;
        logic   req;
    } ctl_s;

endpackage

// File: rtl/rxreq_first_gate.sv
module rxreq_first_gate #(
    parameter int CNT_W      = 8,
    parameter int FIRST_GATE = 64,
    parameter int LL_LEVEL   = 12,
    parameter int LL_DELAY   = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             armed,
    input  logic             restart,
    input  logic             low_latency,
    input  logic [CNT_W-1:0] fifo_count,
    output logic             gate_hit
);
    localparam int LLC_W = $clog2(LL_DELAY + 1) + 1;
    localparam logic [LLC_W-1:0] LLC_MAX = LLC_W'(LL_DELAY);

    logic [LLC_W-1:0] llc_d, llc_q;
    logic             above_ll, above_gate;

    always_comb begin
        above_ll   = fifo_count >= CNT_W'(LL_LEVEL);
        above_gate = fifo_count >= CNT_W'(FIRST_GATE);
        llc_d      = llc_q;
        if (restart || !armed || !above_ll) begin
            llc_d = '0;
        end else if (llc_q < LLC_MAX) begin
            llc_d = llc_q + 1'b1;
        end
        gate_hit = armed && (above_gate ||
                   (low_latency && above_ll && (llc_q == LLC_MAX)));
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            llc_q <= '0;
        end else begin
            llc_q <= llc_d;
        end
    end

endmodule

// File: rtl/rxreq_level_cmp.sv
module rxreq_level_cmp #(
    parameter int CNT_W = 8,
    parameter int WM0   = 16,
    parameter int WM1   = 32,
    parameter int WM2   = 64
) (
    input  logic [1:0]       wm_sel,
    input  logic [CNT_W-1:0] fifo_count,
    output logic             at_wm,
    output logic             nonempty
);
    localparam int NLVL = 4;
    logic [CNT_W-1:0] lvl [NLVL];

    // code 3 reuses the largest level
    for (genvar i = 0; i < NLVL; i++) begin : g_lvl
        if (i == 0) begin : g_l0
            assign lvl[i] = CNT_W'(WM0);
        end else if (i == 1) begin : g_l1
            assign lvl[i] = CNT_W'(WM1);
        end else begin : g_lhi
            assign lvl[i] = CNT_W'(WM2);
        end
    end

    always_comb begin
        at_wm    = fifo_count >= lvl[wm_sel];
        nonempty = fifo_count != '0;
    end

endmodule

// File: rtl/rx_req_gen.sv
module rx_req_gen #(
    parameter int CNT_W      = 8,
    parameter int FIRST_GATE = 64,
    parameter int LL_LEVEL   = 12,
    parameter int LL_DELAY   = 2,
    parameter int WM0        = 16,
    parameter int WM1        = 32,
    parameter int WM2        = 64
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rx_enable,
    input  logic [1:0]       wm_sel,
    input  logic             runt_accept,
    input  logic             low_latency,
    input  logic             frame_start,
    input  logic             frame_end,
    input  logic             addr_match,
    input  logic [CNT_W-1:0] fifo_count,
    output logic             rx_req
);
    import rxreq_pkg::*;

    ctl_s ctl_d, ctl_q;
    logic gate_hit, at_wm, nonempty, have_match;

    rxreq_first_gate #(
        .CNT_W(CNT_W), .FIRST_GATE(FIRST_GATE),
        .LL_LEVEL(LL_LEVEL), .LL_DELAY(LL_DELAY)
    ) u_gate (
        .clk        (clk),
        .rst_n      (rst_n),
        .armed      (ctl_q.phase == PH_FIRST),
        .restart    (frame_start),
        .low_latency(low_latency),
        .fifo_count (fifo_count),
        .gate_hit   (gate_hit)
    );

    rxreq_level_cmp #(
        .CNT_W(CNT_W), .WM0(WM0), .WM1(WM1), .WM2(WM2)
    ) u_lvl (
        .wm_sel    (wm_sel),
        .fifo_count(fifo_count),
        .at_wm     (at_wm),
        .nonempty  (nonempty)
    );

    always_comb begin
        ctl_d      = ctl_q;
        have_match = ctl_q.matched || addr_match;

        if (frame_start) begin
            ctl_d.phase   = PH_FIRST;
            ctl_d.matched = 1'b0;
        end else begin
            ctl_d.matched = have_match;
            unique case (ctl_q.phase)
                PH_FIRST: begin
                    if (frame_end) begin
                        if (runt_accept && !have_match && !gate_hit) begin
                            ctl_d.phase = PH_IDLE;
                        end else begin
                            ctl_d.phase = PH_DRAIN;
                        end
                    end else if (gate_hit) begin
                        ctl_d.phase = PH_BURST;
                    end
                end
                PH_BURST: begin
                    if (frame_end) begin
                        ctl_d.phase = PH_DRAIN;
                    end else if (!nonempty) begin
                        ctl_d.phase = PH_STREAM;
                    end
                end
                PH_STREAM: begin
                    if (frame_end) begin
                        ctl_d.phase = PH_DRAIN;
                    end
                end
                PH_DRAIN: begin
                    if (!nonempty) begin
                        ctl_d.phase = PH_IDLE;
                    end
                end
                default: ctl_d.phase = PH_IDLE;
            endcase
        end

        unique case (ctl_d.phase)
            PH_BURST, PH_DRAIN: ctl_d.req = rx_enable && nonempty;
            PH_STREAM:          ctl_d.req = rx_enable && at_wm;
            default:            ctl_d.req = 1'b0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_q.phase   <= PH_IDLE;
            ctl_q.matched <= 1'b0;
            ctl_q.req     <= 1'b0;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign rx_req = ctl_q.req;

endmodule

// File: rtl/rx_req_gen_chk.sv
module rx_req_gen_chk #(
    parameter int CNT_W      = 8,
    parameter int FIRST_GATE = 64,
    parameter int LL_LEVEL   = 12,
    parameter int WM0        = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              rx_enable,
    input logic [1:0]        wm_sel,
    input logic              runt_accept,
    input logic              frame_start,
    input logic              frame_end,
    input logic              addr_match,
    input logic [CNT_W-1:0]  fifo_count,
    input logic              rx_req,
    input rxreq_pkg::phase_e phase,
    input logic              matched
);
    import rxreq_pkg::*;

    // R5
    enable_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_enable |=> !rx_req);

    // R6
    empty_no_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fifo_count == '0) |=> !rx_req);

    // R2
    early_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_start && fifo_count < CNT_W'(LL_LEVEL)) |=> !rx_req);

    // R3
    wm_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_STREAM && !frame_start && !frame_end && rx_enable &&
         wm_sel == 2'b00 && fifo_count >= CNT_W'(WM0)) |=> rx_req);

    // R8
    runt_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_FIRST && frame_end && !frame_start && runt_accept &&
         !matched && !addr_match && fifo_count < CNT_W'(LL_LEVEL))
        |=> !rx_req);

endmodule

bind rx_req_gen rx_req_gen_chk #(
    .CNT_W(CNT_W), .FIRST_GATE(FIRST_GATE), .LL_LEVEL(LL_LEVEL), .WM0(WM0)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .rx_enable  (rx_enable),
    .wm_sel     (wm_sel),
    .runt_accept(runt_accept),
    .frame_start(frame_start),
    .frame_end  (frame_end),
    .addr_match (addr_match),
    .fifo_count (fifo_count),
    .rx_req     (rx_req),
    .phase      (ctl_q.phase),
    .matched    (ctl_q.matched)
);

// File: tb/tb_rx_req_gen.sv
module tb_rx_req_gen;
    localparam int PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       rx_enable = 1'b1;
    logic [1:0] wm_sel = 2'b00;
    logic       runt_accept = 1'b0;
    logic       low_latency = 1'b0;
    logic       frame_start = 1'b0;
    logic       frame_end = 1'b0;
    logic       addr_match = 1'b0;
    logic [7:0] fifo_count = '0;
    logic       rx_req;

    int total = 0;
    int bad = 0;
    string tag = "R1";
    bit done = 0;

    // reference model state: 0 idle, 1 first, 2 burst, 3 stream, 4 drain
    int  m_ph = 0;
    bit  m_match = 0;
    int  m_llc = 0;
    bit  m_req = 0;

    always #(PERIOD/2) clk = ~clk;

    rx_req_gen dut (
        .clk(clk), .rst_n(rst_n), .rx_enable(rx_enable), .wm_sel(wm_sel),
        .runt_accept(runt_accept), .low_latency(low_latency),
        .frame_start(frame_start), .frame_end(frame_end),
        .addr_match(addr_match), .fifo_count(fifo_count), .rx_req(rx_req)
    );

    function automatic int wm_bytes(input logic [1:0] s);
        if (s == 2'b00) return 16;
        if (s == 2'b01) return 32;
        return 64;
    endfunction

    always @(posedge clk) begin
        int  cnt;
        bit  gate;
        bit  mt;
        cnt = int'(fifo_count);
        if (!rst_n) begin
            m_ph = 0; m_match = 0; m_llc = 0; m_req = 0;
        end else begin
            gate = (m_ph == 1) && (cnt >= 64 ||
                   (low_latency && m_llc >= 2 && cnt >= 12));
            mt = m_match || addr_match;
            if (m_ph == 1 && cnt >= 12 && !frame_start)
                m_llc = (m_llc < 2) ? m_llc + 1 : 2;
            else
                m_llc = 0;
            if (frame_start) begin
                m_ph = 1; m_match = 0;
            end else begin
                m_match = mt;
                if (m_ph == 1) begin
                    if (frame_end) m_ph = (runt_accept && !mt && !gate) ? 0 : 4;
                    else if (gate) m_ph = 2;
                end else if (m_ph == 2) begin
                    if (frame_end) m_ph = 4;
                    else if (cnt == 0) m_ph = 3;
                end else if (m_ph == 3) begin
                    if (frame_end) m_ph = 4;
                end else if (m_ph == 4) begin
                    if (cnt == 0) m_ph = 0;
                end
            end
            m_req = rx_enable && (((m_ph == 2 || m_ph == 4) && cnt != 0) ||
                                  (m_ph == 3 && cnt >= wm_bytes(wm_sel)));
        end
    end

    task automatic check(input bit act, input bit exp, input string why);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s (%s): rx_req=%0b expected=%0b at %0t",
                     tag, why, act, exp, $time);
        end
    endtask

    // R11: every cycle the registered output is compared one edge later
    task automatic cyc();
        @(posedge clk);
        @(negedge clk);
        check(rx_req, m_req, "model");
    endtask

    task automatic pulse_start();
        frame_start = 1'b1; cyc(); frame_start = 1'b0;
    endtask

    task automatic pulse_end();
        frame_end = 1'b1; cyc(); frame_end = 1'b0;
    endtask

    task automatic ramp_to(input int target, input int stp);
        while (int'(fifo_count) != target) begin
            if (int'(fifo_count) < target)
                fifo_count = 8'((int'(fifo_count) + stp > target) ? target : int'(fifo_count) + stp);
            else
                fifo_count = 8'((int'(fifo_count) - stp < target) ? target : int'(fifo_count) - stp);
            cyc();
        end
    endtask

    // full frame: gate, burst emptied, stream fill and drain, end, flush
    task automatic frame_cycle(input logic [1:0] sel, input string t);
        tag = t;
        wm_sel = sel;
        pulse_start();
        ramp_to(63, 1);
        check(rx_req, 1'b0, "63 bytes held off");
        ramp_to(64, 1);
        check(rx_req, 1'b1, "gate at 64");
        ramp_to(0, 8);
        ramp_to(70, 1);
        ramp_to(5, 1);
        ramp_to(20, 1);
        pulse_end();
        ramp_to(0, 3);
        cyc();
    endtask

    initial begin
        #(PERIOD * 150000);
        if (!done) begin
            bad++; total++;
            $display("FAIL watchdog: run hung, expected completion");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        tag = "R1";
        check(rx_req, 1'b0, "reset state");
        fifo_count = 8'd40; cyc(); cyc();
        check(rx_req, 1'b0, "no frame yet");
        fifo_count = 8'd0; cyc();

        frame_cycle(2'b00, "R2");
        frame_cycle(2'b00, "R3");
        frame_cycle(2'b01, "R3");
        frame_cycle(2'b10, "R3");
        frame_cycle(2'b11, "R4");

        // R5: enable masks, tracking continues
        tag = "R5";
        wm_sel = 2'b00;
        pulse_start();
        rx_enable = 1'b0;
        ramp_to(66, 2);
        check(rx_req, 1'b0, "masked while disabled");
        rx_enable = 1'b1; cyc();
        check(rx_req, 1'b1, "burst visible after enable");
        pulse_end();
        tag = "R6";
        ramp_to(1, 5);
        check(rx_req, 1'b1, "drain holds at 1 byte");
        ramp_to(0, 1);
        check(rx_req, 1'b0, "drain closes at 0");
        cyc();

        // R7: runt accept with match
        tag = "R7";
        runt_accept = 1'b1;
        pulse_start();
        ramp_to(20, 2);
        addr_match = 1'b1; cyc(); addr_match = 1'b0;
        ramp_to(30, 2);
        check(rx_req, 1'b0, "short frame before end");
        pulse_end();
        check(rx_req, 1'b1, "request at end with match");
        ramp_to(0, 6); cyc();

        // R7: match in the end cycle
        pulse_start();
        ramp_to(10, 2);
        addr_match = 1'b1; frame_end = 1'b1; cyc();
        addr_match = 1'b0; frame_end = 1'b0;
        check(rx_req, 1'b1, "match with end");
        ramp_to(0, 5); cyc();

        // R8: runt accept no match
        tag = "R8";
        pulse_start();
        ramp_to(30, 3);
        pulse_end();
        check(rx_req, 1'b0, "dropped runt");
        ramp_to(0, 10); cyc();
        check(rx_req, 1'b0, "dropped runt stays quiet");
        runt_accept = 1'b0;

        // R9: short padded frame in normal mode
        tag = "R9";
        pulse_start();
        ramp_to(46, 2);
        pulse_end();
        check(rx_req, 1'b1, "short frame request at end");
        ramp_to(0, 4); cyc();

        // R10: low latency gate
        tag = "R10";
        low_latency = 1'b1;
        pulse_start();
        ramp_to(11, 1);
        fifo_count = 8'd12; cyc();
        check(rx_req, 1'b0, "first cycle at 12");
        cyc();
        check(rx_req, 1'b0, "second cycle at 12");
        cyc();
        check(rx_req, 1'b1, "third cycle at 12");
        ramp_to(0, 3);
        ramp_to(20, 2);
        pulse_end();
        ramp_to(0, 4); cyc();
        low_latency = 1'b0;

        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule